// File: doc/BRIEF.md
# Watchdog Timer with Prescaled Clock Sources

This block is a watchdog timer. It sits on a simple register bus with separate read and write strobes. A 16-bit up-counter advances on ticks from one or more of three clock sources. Each source reaches the block as a one-cycle tick-enable input, and the control register picks which sources count. The block divides the selected tick stream by a power of four before it reaches the counter. When the running counter reaches the programmed compare value, the block emits a one-cycle reset request. The counter then stays where it is until software writes it.

Software keeps the system alive by writing zero into the counter. To reconfigure the block, software first stops counting through the enable register. It then programs the control and compare registers, clears the counter and turns counting back on. Every register reads back its current contents.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the compare value, the enable bit, the counter and the control register are all zero, and `rst_req` is low.
- R2: The register offsets are 0x0 for compare, 0x4 for enable (bit 0), 0x8 for the counter and 0xC for control. Read data appears on `rdata` in the cycle after `rd_en`. Control bits above bit 5 read as zero. Unmapped offsets read as zero.
- R3: A write to offset 0x8 loads the written value into the counter and restarts the prescaler phase. Writing 0 is the keep-alive service.
- R4: Control bits 0, 1 and 2 enable tick inputs 0, 1 and 2 respectively. A cycle in which any enabled input ticks is one source tick, and unselected inputs are ignored.
- R5: With no source bit set, the counter does not advance, even when enabled and with every tick input active.
- R6: Control bits 5:3 set the prescale ratio to 4^n source ticks per count for n = 0 to 5. The ratios are 1, 4, 16, 64, 256 and 1024.
- R7: Prescale field values 6 and 7 divide by 1024.
- R8: While the enable bit is 0, the counter holds its value regardless of ticks.
- R9: When the enabled counter equals the compare value, `rst_req` is high for exactly one cycle, starting in the cycle after the match begins. The counter does not advance past the match.
- R10: After a service write, counting resumes from zero, and a new match produces a new one-cycle request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| tick_src | input | 3 | Tick enables of the three clock sources |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench targets the prescaler edges. It runs exactly 1023 and then 1024 ticks at the clamped ratio. A design that decoded field values 6 or 7 as something other than 1024 would count early or never. An off-by-one terminal count would drift by a count after a few periods.

It drives unselected tick inputs and an empty source mask. A design that let these through would show a nonzero counter.

The bench times the reset request to the exact cycle and counts how many cycles it stays high. A design that re-fired while the counter held at the compare value, or let the counter run past the compare value, would fail these counts. A second request after a service write shows that the match logic re-arms.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int WD_ADDR_W = 4;
   localparam logic [WD_ADDR_W-1:0] WD_OFS_CMP = 4'h0;
   localparam logic [WD_ADDR_W-1:0] WD_OFS_EN  = 4'h4;
   localparam logic [WD_ADDR_W-1:0] WD_OFS_CNT = 4'h8;
   localparam logic [WD_ADDR_W-1:0] WD_OFS_CTL = 4'hC;

   typedef struct packed {
      logic cmp;
      logic en;
      logic cnt;
      logic ctl;
   } wd_hit_t;

   function automatic wd_hit_t wd_decode(input logic [WD_ADDR_W-1:0] a);
      wd_hit_t h;
      h.cmp = (a == WD_OFS_CMP);
      h.en  = (a == WD_OFS_EN);
      h.cnt = (a == WD_OFS_CNT);
      h.ctl = (a == WD_OFS_CTL);
      return h;
   endfunction
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
   import wdog_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_SRC = 3,
   parameter int SEL_W   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [WD_ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]     wdata,
   input  logic [CNT_W-1:0]     cnt_val,
   output logic [CNT_W-1:0]     rdata,
   output logic [CNT_W-1:0]     cmp_q,
   output logic                 en_q,
   output logic [NUM_SRC-1:0]   src_q,
   output logic [SEL_W-1:0]     sel_q,
   output logic                 cnt_load,
   output logic                 ctl_wr
);
   localparam int CTL_W = NUM_SRC + SEL_W;

   wd_hit_t hit;
   assign hit      = wd_decode(addr);
   assign cnt_load = wr_en && hit.cnt;
   assign ctl_wr   = wr_en && hit.ctl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
         en_q  <= 1'b0;
         src_q <= '0;
         sel_q <= '0;
      end else if (wr_en) begin
         if (hit.cmp) cmp_q <= wdata;
         if (hit.en)  en_q  <= wdata[0];
         if (hit.ctl) begin
            src_q <= wdata[NUM_SRC-1:0];
            sel_q <= wdata[NUM_SRC +: SEL_W];
         end
      end
   end

   logic [CNT_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (hit.cmp) rd_mux = cmp_q;
      if (hit.en)  rd_mux = CNT_W'(en_q);
      if (hit.cnt) rd_mux = cnt_val;
      if (hit.ctl) rd_mux = CNT_W'({sel_q, src_q});
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   if (CTL_W > CNT_W) begin : g_ctl_too_wide
      $error("control field does not fit the data width");
   end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int NUM_SRC = 3,
   parameter int SEL_W   = 3,
   parameter int MAX_SEL = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] tick_src,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [SEL_W-1:0]   sel,
   input  logic               clr,
   output logic               step
);
   localparam int PS_W = 2 * MAX_SEL;

   logic [NUM_SRC-1:0] gated;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      assign gated[i] = tick_src[i] & src_en[i];
   end
   logic any_tick;
   assign any_tick = |gated;

   if (MAX_SEL == 0) begin : g_nodiv
      logic unused_sel;
      assign unused_sel = ^{sel, clr, clk, rst_n};
      assign step = any_tick;
   end else begin : g_div
      logic [SEL_W-1:0] eff_sel;
      logic [PS_W-1:0]  lim;
      logic [PS_W-1:0]  pcnt;

      assign eff_sel = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;

      always_comb begin
         lim = '0;
         for (int k = 0; k < MAX_SEL; k++)
            if (k < int'(eff_sel)) lim[2*k +: 2] = 2'b11;
      end

      assign step = any_tick && (pcnt == lim);

      always_ff @(posedge clk) begin
         if (!rst_n || clr) pcnt <= '0;
         else if (any_tick) pcnt <= step ? '0 : pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             rst_req
);
   logic at_cmp, match, match_q;
   assign at_cmp = (cnt == cmp);
   assign match  = en && at_cmp;

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt <= '0;
      else if (load)                  cnt <= load_val;
      else if (en && step && !at_cmp) cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         match_q <= match;
         rst_req <= match && !match_q;
      end
   end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_SRC = 3,
   parameter int SEL_W   = 3,
   parameter int MAX_SEL = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [WD_ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]     wdata,
   output logic [CNT_W-1:0]     rdata,
   input  logic [NUM_SRC-1:0]   tick_src,
   output logic                 rst_req
);
   logic [CNT_W-1:0]   cmp_q, cnt_q;
   logic               en_q, cnt_load, ctl_wr, step, ps_clr;
   logic [NUM_SRC-1:0] src_q;
   logic [SEL_W-1:0]   sel_q;

   if (NUM_SRC < 1) begin : g_bad_src
      $error("at least one clock source required");
   end
   if (MAX_SEL >= (1 << SEL_W)) begin : g_bad_sel
      $error("prescale field too narrow for MAX_SEL");
   end

   wdog_regfile #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .cnt_val(cnt_q), .rdata(rdata), .cmp_q(cmp_q),
      .en_q(en_q), .src_q(src_q), .sel_q(sel_q), .cnt_load(cnt_load),
      .ctl_wr(ctl_wr)
   );

   assign ps_clr = !en_q || ctl_wr || cnt_load;

   wdog_prescale #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_ps (
      .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .src_en(src_q),
      .sel(sel_q), .clr(ps_clr), .step(step)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en_q), .step(step), .load(cnt_load),
      .load_val(wdata), .cmp(cmp_q), .cnt(cnt_q), .rst_req(rst_req)
   );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int CNT_W   = 16,
   parameter int NUM_SRC = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rd_en,
   input logic [3:0]         addr,
   input logic [CNT_W-1:0]   rdata,
   input logic               rst_req,
   input logic               cnt_load,
   input logic               en_q,
   input logic [NUM_SRC-1:0] src_q,
   input logic [CNT_W-1:0]   cnt_q,
   input logic [CNT_W-1:0]   cmp_q
);
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R9
   AST_PULSE_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cnt_q == cmp_q && !cnt_load) |=> (cnt_q == cmp_q)); // R9
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cnt_load) |=> $stable(cnt_q)); // R8
   AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == '0 && !cnt_load) |=> $stable(cnt_q)); // R5
   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_load |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R6
   AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 4'hC) |=> (rdata[CNT_W-1:6] == '0)); // R2
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) i_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
   .rst_req(rst_req), .cnt_load(cnt_load), .en_q(en_q), .src_q(src_q),
   .cnt_q(cnt_q), .cmp_q(cmp_q)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [2:0]  tick_src = '0;
   logic        rst_req;

   int errors = 0, checks = 0, pulses = 0, first_pulse = -1;
   bit done = 0;

   wdog_timer i_wdog_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick_src(tick_src), .rst_req(rst_req)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic run(input int n, input logic [2:0] m);
      pulses = 0; first_pulse = -1;
      for (int i = 0; i < n; i++) begin
         tick_src = m;
         @(negedge clk);
         if (rst_req) begin
            pulses++;
            if (first_pulse < 0) first_pulse = i;
         end
      end
      tick_src = '0;
   endtask

   task automatic cfg(input logic [15:0] ctl, input logic [15:0] cmp);
      wr(4'h4, 16'h0);
      wr(4'hC, ctl);
      wr(4'h0, cmp);
      wr(4'h8, 16'h0);
      wr(4'h4, 16'h1);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 rst_req", int'(rst_req), 0);
      rd(4'h0, d); chk("R1 compare", int'(d), 0);
      rd(4'h4, d); chk("R1 enable", int'(d), 0);
      rd(4'h8, d); chk("R1 counter", int'(d), 0);
      rd(4'hC, d); chk("R1 control", int'(d), 0);
   endtask

   task automatic t_readback();
      logic [15:0] d;
      wr(4'hC, 16'hFFFF); rd(4'hC, d); chk("R2 control upper bits", int'(d), 'h3F);
      wr(4'h0, 16'hA5C3); rd(4'h0, d); chk("R2 compare", int'(d), 'hA5C3);
      wr(4'h8, 16'h0100); rd(4'h8, d); chk("R3 counter load", int'(d), 'h0100);
      wr(4'h4, 16'h0003); rd(4'h4, d); chk("R2 enable bit0", int'(d), 1);
      wr(4'h4, 16'h0000); rd(4'h4, d); chk("R2 enable clear", int'(d), 0);
      rd(4'h2, d); chk("R2 unmapped", int'(d), 0);
   endtask

   task automatic t_sources();
      logic [15:0] d;
      cfg(16'h0001, 16'hFFFF);
      run(5, 3'b001); rd(4'h8, d); chk("R4 src0 div1", int'(d), 5);
      cfg(16'h0002, 16'hFFFF);
      run(5, 3'b101); rd(4'h8, d); chk("R4 unselected ignored", int'(d), 0);
      run(5, 3'b010); rd(4'h8, d); chk("R4 src1", int'(d), 5);
      cfg(16'h0004, 16'hFFFF);
      run(4, 3'b011); rd(4'h8, d); chk("R4 src2 ignores 0,1", int'(d), 0);
      run(4, 3'b100); rd(4'h8, d); chk("R4 src2", int'(d), 4);
      cfg(16'h0003, 16'hFFFF);
      run(4, 3'b011); rd(4'h8, d); chk("R4 two sources same cycle", int'(d), 4);
      cfg(16'h0000, 16'hFFFF);
      run(6, 3'b111); rd(4'h8, d); chk("R5 no source", int'(d), 0);
   endtask

   task automatic t_prescale();
      logic [15:0] d;
      cfg(16'h0009, 16'hFFFF);
      run(12, 3'b001); rd(4'h8, d); chk("R6 div4", int'(d), 3);
      cfg(16'h0011, 16'hFFFF);
      run(32, 3'b001); rd(4'h8, d); chk("R6 div16", int'(d), 2);
      cfg(16'h0019, 16'hFFFF);
      run(127, 3'b001); rd(4'h8, d); chk("R6 div64", int'(d), 1);
      cfg(16'h0029, 16'hFFFF);
      run(2048, 3'b001); rd(4'h8, d); chk("R6 div1024", int'(d), 2);
      cfg(16'h0039, 16'hFFFF);
      run(1023, 3'b001); rd(4'h8, d); chk("R7 sel7 before edge", int'(d), 0);
      run(1, 3'b001); rd(4'h8, d); chk("R7 sel7 at 1024", int'(d), 1);
      cfg(16'h0031, 16'hFFFF);
      run(1024, 3'b001); rd(4'h8, d); chk("R7 sel6", int'(d), 1);
   endtask

   task automatic t_disable();
      logic [15:0] d;
      cfg(16'h0001, 16'hFFFF);
      run(4, 3'b001);
      wr(4'h4, 16'h0);
      run(5, 3'b001); rd(4'h8, d); chk("R8 hold when disabled", int'(d), 4);
   endtask

   task automatic t_compare();
      logic [15:0] d;
      cfg(16'h0001, 16'h0003);
      run(10, 3'b001);
      chk("R9 one pulse", pulses, 1);
      chk("R9 pulse cycle", first_pulse, 3);
      rd(4'h8, d); chk("R9 counter holds", int'(d), 3);
      wr(4'h8, 16'h0);
      rd(4'h8, d); chk("R10 service clears", int'(d), 0);
      run(10, 3'b001);
      chk("R10 second pulse", pulses, 1);
      chk("R10 second pulse cycle", first_pulse, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_sources();
      t_prescale();
      t_disable();
      t_compare();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule